// File: doc/BRIEF.md
# Vector Readout Bus-Hold Sequencer

This block fetches one horizontal/vertical coordinate pair per readout cycle from memory it shares with a host processor, and delivers the pair as two 12-bit DAC words. It gets the memory by asking the host for the bus through an active-low hold request and waiting for the host's acknowledge. Once the grant arrives it asserts an active-low readout enable and drives a readout address built from an internal word counter. It then runs two read cycles, loading the first word into the horizontal DAC register and the second into the vertical one, and gives the bus back.

Fetching is paced by the display line structure. A down-counter steps once per line sync pulse and reloads itself when it borrows, so it repeats every seven lines. Four of those lines are readout lines and three are waveform lines. A fetch request is sampled from a control input on a slow strobe. It is only acted on during a readout line and stays pending until one comes. If the host never grants the bus, a timeout releases the request and reports it with a one-cycle flag.

Top module: `vro_readout_seq`

## Requirements
- R1: After reset, hold_n and roen_n are 1, mem_addr is 0, dac_x and dac_y are 0, and grant_tmo is 0.
- R2: The line counter is set to LINES-1 (6) by reset, steps down by one on each line_sync, and reloads LINES-1 on the sync after it reaches 0. A line is a readout line while the counter is below RO_LINES (4). With the defaults, this makes lines 4 to 7 after reset readout lines and lines 1 to 3 waveform lines.
- R3: ctrl_go is taken into the request flag only in a cycle with ctrl_tick high. With ctrl_tick low, ctrl_go has no effect and hold_n stays 1.
- R4: A sampled request starts a fetch, with hold_n falling, only while the current line is a readout line. A request made on a waveform line stays pending and starts once a readout line begins.
- R5: While the block waits for the grant, roen_n stays 1. roen_n goes to 0 in the cycle after hold_ack is sampled high while hold_n is 0.
- R6: While roen_n is 0, mem_addr[17:14] is 4'hF, mem_addr[13] is 0, mem_addr[12:2] holds the word counter, mem_addr[0] is 0, and mem_addr[1] is 0 for the first word and 1 for the second.
- R7: roen_n stays 0 for two read cycles of RD_CYC clocks each (4 clocks with the defaults). At the end of the first read cycle dac_x takes mem_data[11:0], and at the end of the second dac_y takes mem_data[11:0]. mem_data[15:12] is ignored.
- R8: In the cycle after the second word is captured, hold_n and roen_n are both 1 and mem_addr is 0.
- R9: The word counter increases by one after every completed fetch.
- R10: The word counter returns to 0 on the line_sync that reloads the line counter. When that sync arrives in the same cycle a fetch completes, the counter still ends at 0.
- R11: If hold_ack is not sampled high within TMO_CYC consecutive request cycles, hold_n returns to 1 after exactly TMO_CYC cycles low. grant_tmo is 1 for one cycle, the DAC words and the word counter keep their values, and no read happens. A grant sampled in the last of those cycles still proceeds with a normal fetch and no grant_tmo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_sync | input | 1 | One-cycle pulse per horizontal line |
| ctrl_tick | input | 1 | Slow sampling strobe for ctrl_go |
| ctrl_go | input | 1 | Fetch request, sampled on ctrl_tick |
| hold_n | output | 1 | Active-low bus hold request to the host |
| hold_ack | input | 1 | Host bus grant |
| roen_n | output | 1 | Active-low readout enable |
| mem_addr | output | 18 | Readout address, 0 when roen_n is 1 |
| mem_data | input | 16 | Read data from shared memory |
| dac_x | output | 12 | Horizontal DAC word |
| dac_y | output | 12 | Vertical DAC word |
| grant_tmo | output | 1 | One-cycle pulse when the grant timed out |

## Verification
The hardest case to reach is a line sync that reloads the line counter in the very clock where a fetch completes, because both the clear and the increment of the word counter land on the same edge. The stimulus walks the line counter to its last readout line, issues a fetch, and counts the clocks that roen_n is low. It pulses line_sync in the final read clock and then confirms that the next fetch reads word 0. The grant that arrives in the last timeout cycle is reached in a similar way: the host model delays its acknowledge by TMO_CYC-1 clocks after hold_n falls.

// File: rtl/vro_pkg.sv
package vro_pkg;
  localparam int BUS_AW = 18;
  localparam int CTR_W  = 11;
  localparam int DAT_W  = 16;
  localparam int DAC_W  = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD1, ST_RD2} vro_state_e;

  // readout address: top nibble forced high, counter on bits 12..2, word select on bit 1
  function automatic logic [BUS_AW-1:0] ro_addr(input logic [CTR_W-1:0] c, input logic second);
    return {4'hF, 1'b0, c, second, 1'b0};
  endfunction

  // DAC word is the low part of the data bus
  function automatic logic [DAC_W-1:0] dac_word(input logic [DAT_W-1:0] d);
    return d[DAC_W-1:0];
  endfunction
endpackage

// File: rtl/vro_line_phase.sv
module vro_line_phase #(
  parameter int LINES    = 7,
  parameter int RO_LINES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sync,
  output logic ro_line,
  output logic period_wrap
);
  localparam int LW = (LINES > 2) ? $clog2(LINES) : 1;

  logic [LW-1:0] lc;
  logic          borrow;

  assign borrow      = (lc == '0);
  assign period_wrap = line_sync && borrow;
  assign ro_line     = (lc < LW'(RO_LINES));

  always_ff @(posedge clk) begin
    if (!rst_n)          lc <= LW'(LINES - 1);
    else if (line_sync)  lc <= borrow ? LW'(LINES - 1) : lc - LW'(1);
  end

  // R2
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n) lc <= LW'(LINES - 1));
  // R2
  line_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_sync |=> $stable(ro_line));
endmodule

// File: rtl/vro_addr_ctr.sv
module vro_addr_ctr #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + CW'(1);
  end

  // R10
  ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) clr |=> cnt == '0);
  // R9
  ctr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/vro_fsm.sv
module vro_fsm
  import vro_pkg::*;
#(
  parameter int RD_CYC  = 2,
  parameter int TMO_CYC = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ro_line,
  input  logic              ctrl_tick,
  input  logic              ctrl_go,
  input  logic              hold_ack,
  input  logic [DAT_W-1:0]  mem_data,
  input  logic [CTR_W-1:0]  ctr,
  output logic              hold_n,
  output logic              roen_n,
  output logic [BUS_AW-1:0] mem_addr,
  output logic [DAC_W-1:0]  dac_x,
  output logic [DAC_W-1:0]  dac_y,
  output logic              grant_tmo,
  output logic              fetch_done
);
  localparam int RCW = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;
  localparam int TW  = $clog2(TMO_CYC + 1);

  vro_state_e     st, st_nx;
  logic           go_q;
  logic [RCW-1:0] rd_cnt;
  logic [TW-1:0]  tmo_cnt;
  logic           start, rd_last, tmo_last, latch1, latch2, tmo_hit, reading;

  assign start    = (st == ST_IDLE) && go_q && ro_line;
  assign reading  = (st == ST_RD1) || (st == ST_RD2);
  assign rd_last  = (rd_cnt == RCW'(RD_CYC - 1));
  assign tmo_last = (tmo_cnt == TW'(TMO_CYC - 1));
  assign latch1   = (st == ST_RD1) && rd_last;
  assign latch2   = (st == ST_RD2) && rd_last;
  assign tmo_hit  = (st == ST_REQ) && !hold_ack && tmo_last;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (start)    st_nx = ST_REQ;
      ST_REQ:  if (hold_ack) st_nx = ST_RD1;
               else if (tmo_last) st_nx = ST_IDLE;
      ST_RD1:  if (rd_last)  st_nx = ST_RD2;
      ST_RD2:  if (rd_last)  st_nx = ST_IDLE;
      default:               st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      go_q      <= 1'b0;
      rd_cnt    <= '0;
      tmo_cnt   <= '0;
      dac_x     <= '0;
      dac_y     <= '0;
      grant_tmo <= 1'b0;
    end else begin
      st        <= st_nx;
      go_q      <= ctrl_tick ? ctrl_go : (go_q && !start);
      rd_cnt    <= (reading && !rd_last) ? rd_cnt + RCW'(1) : '0;
      tmo_cnt   <= ((st == ST_REQ) && !hold_ack && !tmo_last) ? tmo_cnt + TW'(1) : '0;
      grant_tmo <= tmo_hit;
      if (latch1) dac_x <= dac_word(mem_data);
      if (latch2) dac_y <= dac_word(mem_data);
    end
  end

  assign fetch_done = latch2;
  assign hold_n     = (st == ST_IDLE);
  assign roen_n     = !reading;
  assign mem_addr   = roen_n ? '0 : ro_addr(ctr, st == ST_RD2);

  // R4
  start_on_ro_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_n) |-> $past(ro_line));
  // R5
  roen_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(roen_n) |-> $past(hold_ack) && $past(!hold_n));
  // R6
  addr_top_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !roen_n |-> (mem_addr[17:14] == 4'hF) && !hold_n);
  // R7
  dac_x_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_x) |-> $past(st == ST_RD1));
  // R11
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_tmo |-> hold_n && $past(!hold_n));
endmodule

// File: rtl/vro_readout_seq.sv
module vro_readout_seq
  import vro_pkg::*;
#(
  parameter int LINES    = 7,
  parameter int RO_LINES = 4,
  parameter int RD_CYC   = 2,
  parameter int TMO_CYC  = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_sync,
  input  logic              ctrl_tick,
  input  logic              ctrl_go,
  output logic              hold_n,
  input  logic              hold_ack,
  output logic              roen_n,
  output logic [BUS_AW-1:0] mem_addr,
  input  logic [DAT_W-1:0]  mem_data,
  output logic [DAC_W-1:0]  dac_x,
  output logic [DAC_W-1:0]  dac_y,
  output logic              grant_tmo
);
  logic             ro_line, period_wrap, fetch_done;
  logic [CTR_W-1:0] ctr;

  vro_line_phase #(.LINES(LINES), .RO_LINES(RO_LINES)) u_line (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync),
    .ro_line(ro_line), .period_wrap(period_wrap)
  );

  vro_addr_ctr #(.CW(CTR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(fetch_done), .clr(period_wrap), .cnt(ctr)
  );

  vro_fsm #(.RD_CYC(RD_CYC), .TMO_CYC(TMO_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ro_line(ro_line), .ctrl_tick(ctrl_tick),
    .ctrl_go(ctrl_go), .hold_ack(hold_ack), .mem_data(mem_data), .ctr(ctr),
    .hold_n(hold_n), .roen_n(roen_n), .mem_addr(mem_addr), .dac_x(dac_x),
    .dac_y(dac_y), .grant_tmo(grant_tmo), .fetch_done(fetch_done)
  );

  // R8
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_n) |-> roen_n && (mem_addr == '0));
endmodule

// File: tb/tb_vro_readout_seq.sv
module tb_vro_readout_seq;
  localparam int TMO = 16;
  localparam int RD  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_sync = 1'b0, ctrl_tick = 1'b0, ctrl_go = 1'b0, hold_ack = 1'b0;
  logic hold_n, roen_n, grant_tmo;
  logic [17:0] mem_addr;
  logic [15:0] mem_data, cur_x = '0, cur_y = '0;
  logic [11:0] dac_x, dac_y;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lowc;
  logic [17:0] a0, a1;
  logic started, tmo_seen, roen_early, first_roen;
  logic [10:0] exp_ctr = '0;

  assign mem_data = mem_addr[1] ? cur_y : cur_x;

  vro_readout_seq #(.TMO_CYC(TMO), .RD_CYC(RD)) dut (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .ctrl_tick(ctrl_tick),
    .ctrl_go(ctrl_go), .hold_n(hold_n), .hold_ack(hold_ack), .roen_n(roen_n),
    .mem_addr(mem_addr), .mem_data(mem_data), .dac_x(dac_x), .dac_y(dac_y),
    .grant_tmo(grant_tmo)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // x word, y word, grant delay
  localparam logic [39:0] VEC [6] = '{
    {16'hF123, 16'h0ABC, 8'd0},
    {16'h0FFF, 16'hA000, 8'd1},
    {16'h5555, 16'hAAAA, 8'd3},
    {16'h8001, 16'h7FFE, 8'd5},
    {16'hC3C3, 16'h3C3C, 8'd2},
    {16'h0000, 16'hFFFF, 8'd9}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sync_line();
    @(negedge clk) line_sync = 1'b1;
    @(negedge clk) line_sync = 1'b0;
  endtask

  task automatic request();
    @(negedge clk) begin ctrl_tick = 1'b1; ctrl_go = 1'b1; end
    @(negedge clk) begin ctrl_tick = 1'b0; ctrl_go = 1'b0; end
  endtask

  task automatic stays_high(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!hold_n) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic serve(input int gdelay, input logic sync_end);
    int guard = 0;
    started = 0; tmo_seen = 0; roen_early = 0; lowc = 0; a0 = '0; a1 = '0;
    for (int i = 0; i < 40 && !started; i++) begin
      @(negedge clk);
      if (!hold_n) started = 1;
    end
    for (int i = 0; i < gdelay; i++) begin
      @(negedge clk);
      if (!roen_n) roen_early = 1;
    end
    hold_ack = 1'b1;
    @(negedge clk);
    first_roen = roen_n;
    while (!hold_n && guard < 200) begin
      if (!roen_n) begin
        lowc++;
        if (mem_addr[1]) a1 = mem_addr; else a0 = mem_addr;
      end
      if (grant_tmo) tmo_seen = 1;
      line_sync = sync_end && !roen_n && (lowc == 2 * RD);
      @(negedge clk);
      guard++;
    end
    line_sync = 1'b0;
    hold_ack = 1'b0;
  endtask

  task automatic fetch_checks(input logic [15:0] x, input logic [15:0] y);
    chk("R4 fetch started", started, 1);
    chk("R5 roen_n high before grant", roen_early, 0);
    chk("R5 roen_n low after grant", first_roen, 0);
    chk("R7 readout length", lowc, 2 * RD);
    chk("R6 first word address", a0, {4'hF, 1'b0, exp_ctr, 2'b00});
    chk("R6 second word address", a1, {4'hF, 1'b0, exp_ctr, 2'b10});
    chk("R7 dac_x word", dac_x, x[11:0]);
    chk("R7 dac_y word", dac_y, y[11:0]);
    chk("R8 release", {hold_n, roen_n, mem_addr}, {2'b11, 18'h0});
    chk("R11 no timeout flag", tmo_seen, 0);
  endtask

  task automatic do_fetch(input logic [15:0] x, input logic [15:0] y,
                          input int gdelay, input logic sync_end);
    cur_x = x; cur_y = y;
    request();
    serve(gdelay, sync_end);
    fetch_checks(x, y);
    exp_ctr = sync_end ? '0 : exp_ctr + 11'd1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 hold_n", hold_n, 1);
    chk("R1 roen_n", roen_n, 1);
    chk("R1 mem_addr", mem_addr, 0);
    chk("R1 dac words", {dac_x, dac_y}, 0);
    chk("R1 grant_tmo", grant_tmo, 0);
    rst_n = 1'b1;

    // R4: request on a waveform line stays pending, starts on the first readout line
    cur_x = 16'hE246; cur_y = 16'h1357;
    request();
    stays_high(20, "R4 no start on waveform line");
    sync_line(); sync_line(); sync_line();
    serve(1, 1'b0);
    fetch_checks(16'hE246, 16'h1357);
    exp_ctr = exp_ctr + 11'd1;

    // R3: ctrl_go without ctrl_tick is ignored
    @(negedge clk) ctrl_go = 1'b1;
    stays_high(20, "R3 ctrl_go without tick");
    ctrl_go = 1'b0;

    // R7 R9: table of word pairs and grant delays
    for (int v = 0; v < 6; v++)
      do_fetch(VEC[v][39:24], VEC[v][23:8], int'(VEC[v][7:0]), 1'b0);

    // R11: no grant at all
    cur_x = 16'h0111; cur_y = 16'h0222;
    request();
    started = 0;
    for (int i = 0; i < 40 && !started; i++) begin
      @(negedge clk);
      if (!hold_n) started = 1;
    end
    lowc = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!hold_n) lowc++; else break;
    end
    chk("R11 hold low cycles", lowc, TMO);
    chk("R11 grant_tmo pulse", grant_tmo, 1);
    @(negedge clk);
    chk("R11 grant_tmo one cycle", grant_tmo, 0);
    chk("R11 dac words kept", {dac_x, dac_y}, {VEC[5][35:24], VEC[5][19:8]});
    chk("R11 hold released", hold_n, 1);

    // R11: grant in the last allowed cycle; R9 counter unchanged by the timeout
    do_fetch(16'h9ABC, 16'h4DEF, TMO - 1, 1'b0);

    // R10: line wrap in the same cycle the fetch completes
    sync_line(); sync_line(); sync_line();
    do_fetch(16'h1F2E, 16'h3D4C, 2, 1'b1);

    // R2: after wrap, lines at count 6, 5, 4 are waveform lines
    cur_x = 16'h7A7A; cur_y = 16'h0B0B;
    request();
    stays_high(10, "R2 line count 6 waveform");
    sync_line();
    stays_high(10, "R2 line count 5 waveform");
    sync_line();
    stays_high(10, "R2 line count 4 waveform");
    sync_line();
    serve(0, 1'b0);
    fetch_checks(16'h7A7A, 16'h0B0B);
    exp_ctr = exp_ctr + 11'd1;

    // R9 then R10 plain wrap clear
    do_fetch(16'h2468, 16'h8642, 1, 1'b0);
    sync_line(); sync_line(); sync_line(); sync_line();
    exp_ctr = '0;
    sync_line(); sync_line(); sync_line();
    do_fetch(16'h6006, 16'h0660, 0, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule